// File: doc/BRIEF.md
# Round-robin PCI bus arbiter

This block decides which of several PCI initiators owns the bus. The low-numbered requesters are internal initiators of the chip; the rest are external boards on the backplane. Each has an active-low request pin and an active-low grant pin. Ownership rotates in a fair circular order, so one busy initiator cannot lock out the others. When nobody asks for the bus, the grant stays parked on whoever held it last.

The arbiter watches FRAME# and IRDY# to tell an idle bus from a busy one. It never takes the grant away while a transfer is running. An internal owner keeps the grant for as long as it keeps requesting.

An external owner can hold a grant and never start a cycle. After a fixed number of idle granted clocks, the arbiter declares that owner broken. It then ignores that owner's request pin until the pin is seen released, and sets a sticky status flag. The flag drives an interrupt line through an enable input. While the flag is set, FRAME# no longer counts as bus activity; only IRDY# does. A synchronous soft-reset input and the asynchronous hard reset both return everything to the starting state.

Top module: `pci_rr_arbiter`

## Requirements
- R1: During hard reset every GNT# is high and the broken status is 0. On the first clock after reset release, the grant is parked on requester 0 (gnt_n bit 0 low).
- R2: When the owner gives up the bus and others are waiting, the next owner is the first active requester found when scanning from owner+1 upward, wrapping from the top index back to 0.
- R3: If no other requester is eligible when the owner lets go, the grant stays on the current owner with no gap.
- R4: At most one GNT# is low at any time. Whenever ownership changes, all GNT# are high for exactly one clock before the new grant appears.
- R5: An internal owner (index below N_INT) keeps its grant while its REQ# stays low, even if others request.
- R6: While the bus is busy (FRAME# or IRDY# low), the grant never moves. An external owner gives up the grant only when the bus is idle and either its REQ# is high or it has started a transaction under the current grant.
- R7: An external owner that keeps REQ# low with the bus idle for IDLE_CLOCKS consecutive granted clocks is declared broken on the IDLE_CLOCKS-th such clock. The broken status then stays set until a reset. Bus activity on that clock prevents the declaration.
- R8: A broken master's REQ# is ignored until that REQ# is sampled high. After that, the master is eligible again.
- R9: While the broken status is set, FRAME# low alone does not count as bus activity; only IRDY# low does.
- R10: irq is high exactly when the broken status is set and irq_en is high.
- R11: A soft reset clears the status and all request masks, removes the grant for one clock, and then parks the grant on requester 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| req_n | input | N_INT+N_EXT | Bus requests, active low; internal initiators at the low indices |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| irq_en | input | 1 | Enable for the broken-master interrupt |
| gnt_n | output | N_INT+N_EXT | Bus grants, active low |
| broken_status | output | 1 | Sticky broken-master flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can meet on the same clock. The idle-timeout expiry can coincide with a transaction start, and a broken declaration can coincide with a grant handover. The bench provokes the first by holding a granted external master idle for one clock fewer than the limit and then asserting FRAME# on the very clock where the counter would expire. It judges the result by the status flag staying clear. The second is provoked by a waiting requester at expiry: the bench expects the one-clock gap and then the grant at the next requester in circular order, with FRAME# held low throughout, which is ignored once the flag is set.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
  // Index of the requester after idx in circular order over n slots.
  function automatic int wrap_next(int idx, int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/pci_arb_rr_pick.sv
module pci_arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!found && cand[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
  end
endmodule

// File: rtl/pci_arb_idle_watch.sv
module pci_arb_idle_watch #(
  parameter int LIMIT = 16,
  localparam int CW   = $clog2(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic count_en,
  output logic expire
);
  logic [CW-1:0] cnt;

  assign expire = count_en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || !count_en) cnt <= '0;
    else if (expire)           cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pci_arb_mask.sv
module pci_arb_mask #(
  parameter int N_INT = 2,
  parameter int N_EXT = 2,
  localparam int N    = N_INT + N_EXT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [N-1:0] req_n,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] mask
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i < N_INT) begin : g_int
      assign mask[i] = 1'b0;
    end else begin : g_ext
      logic m;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          m <= 1'b0;
        else if (soft_rst)   m <= 1'b0;
        else if (set_vec[i]) m <= 1'b1;
        else if (req_n[i])   m <= 1'b0;
      end
      assign mask[i] = m;
    end
  end
endmodule

// File: rtl/pci_rr_arbiter.sv
module pci_rr_arbiter
  import pci_arb_pkg::*;
#(
  parameter int N_INT       = 2,
  parameter int N_EXT       = 2,
  parameter int IDLE_CLOCKS = 16,
  localparam int N          = N_INT + N_EXT,
  localparam int IW         = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [N-1:0] req_n,
  input  logic         frame_n,
  input  logic         irdy_n,
  input  logic         irq_en,
  output logic [N-1:0] gnt_n,
  output logic         broken_status,
  output logic         irq
);
  logic          gnt_on;
  logic [IW-1:0] owner;
  logic          used;
  logic          status_q;

  logic [N-1:0]  mask;
  logic [N-1:0]  eff;
  logic [N-1:0]  others;
  logic [N-1:0]  set_vec;
  logic [IW-1:0] start;
  logic [IW-1:0] pick;
  logic          found;
  logic          act;
  logic          owner_req;
  logic          owner_ext;
  logic          count_en;
  logic          expire;
  logic          release_ok;
  logic          move;

  // Activity: once broken, FRAME# alone is disregarded
  assign act       = status_q ? !irdy_n : (!frame_n || !irdy_n);
  assign eff       = ~req_n & ~mask;
  assign owner_req = eff[owner];
  assign owner_ext = int'(owner) >= N_INT;
  assign others    = eff & ~(N'(1) << owner);
  assign start     = IW'(wrap_next(int'(owner), N));

  assign count_en   = gnt_on && owner_ext && owner_req && !act;
  assign release_ok = gnt_on && !act &&
                      (owner_ext ? (!owner_req || used) : !owner_req);
  assign move       = (release_ok || expire) && found;
  assign set_vec    = expire ? (N'(1) << owner) : '0;

  pci_arb_rr_pick #(.N(N), .IW(IW)) u_pick (
    .cand  (others),
    .start (start),
    .found (found),
    .pick  (pick)
  );

  pci_arb_idle_watch #(.LIMIT(IDLE_CLOCKS)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .count_en (count_en),
    .expire   (expire)
  );

  pci_arb_mask #(.N_INT(N_INT), .N_EXT(N_EXT)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .req_n    (req_n),
    .set_vec  (set_vec),
    .mask     (mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_on   <= 1'b0;
      owner    <= '0;
      used     <= 1'b0;
      status_q <= 1'b0;
    end else if (soft_rst) begin
      gnt_on   <= 1'b0;
      owner    <= '0;
      used     <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (!gnt_on) begin
        gnt_on <= 1'b1;
        used   <= 1'b0;
      end else if (move) begin
        gnt_on <= 1'b0;
        owner  <= pick;
        used   <= 1'b0;
      end else if (act) begin
        used <= 1'b1;
      end
      if (expire) status_q <= 1'b1;
    end
  end

  always_comb begin
    gnt_n = '1;
    if (gnt_on) gnt_n[owner] = 1'b0;
  end

  assign broken_status = status_q;
  assign irq           = status_q && irq_en;
endmodule

// File: rtl/pci_rr_arbiter_chk.sv
module pci_rr_arbiter_chk #(
  parameter int N_INT = 2,
  parameter int N_EXT = 2,
  localparam int N    = N_INT + N_EXT
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_rst,
  input logic [N-1:0] req_n,
  input logic [N-1:0] gnt_n,
  input logic         frame_n,
  input logic         irdy_n,
  input logic         broken_status
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) <= 1); // R4

  AST_GAP_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n) && !(&$past(gnt_n))) |-> (gnt_n == $past(gnt_n))); // R4

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n) && (&req_n) && !soft_rst) |=> (gnt_n == $past(gnt_n))); // R3

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n) && !(frame_n && irdy_n) && !broken_status && !soft_rst)
      |=> (gnt_n == $past(gnt_n))); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (broken_status && !soft_rst) |=> broken_status); // R7

  for (genvar i = 0; i < N_INT; i++) begin : g_int_keep
    AST_INT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_n[i] && !req_n[i] && !soft_rst) |=> !gnt_n[i]); // R5
  end
endmodule

bind pci_rr_arbiter pci_rr_arbiter_chk #(.N_INT(N_INT), .N_EXT(N_EXT)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .req_n         (req_n),
  .gnt_n         (gnt_n),
  .frame_n       (frame_n),
  .irdy_n        (irdy_n),
  .broken_status (broken_status)
);

// File: tb/pci_rr_arbiter_tb_top.sv
`timescale 1ns/1ps
module pci_rr_arbiter_tb_top;
  localparam int NM = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          soft_rst;
  logic [NM-1:0] req_n;
  logic          frame_n;
  logic          irdy_n;
  logic          irq_en;
  logic [NM-1:0] gnt_n;
  logic          broken_status;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pci_rr_arbiter #(.N_INT(2), .N_EXT(2), .IDLE_CLOCKS(16)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .req_n         (req_n),
    .frame_n       (frame_n),
    .irdy_n        (irdy_n),
    .irq_en        (irq_en),
    .gnt_n         (gnt_n),
    .broken_status (broken_status),
    .irq           (irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [NM-1:0] gnt_of(input int idx);
    return ~(NM'(1) << idx);
  endfunction

  // Soft reset, then leave requester o granted and still requesting
  task automatic take(input int o);
    soft_rst = 1'b1;
    step(1);
    soft_rst = 1'b0;
    step(1);
    if (o != 0) begin
      req_n = gnt_of(o);
      step(2);
    end
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; req_n = '1;
    frame_n = 1'b1; irdy_n = 1'b1; irq_en = 1'b1;
    step(3);
    check(gnt_n == '1, "R1", "gnt during reset", gnt_n, 4'hF);
    check(broken_status == 1'b0, "R1", "status during reset", broken_status, 0);
    rst_n = 1'b1;
    step(1);
    check(gnt_n == gnt_of(0), "R1", "parked after reset", gnt_n, gnt_of(0));

    // R2 / R3 / R4 sweep: every owner, every pattern of other requesters
    for (int o = 0; o < NM; o++) begin
      for (int p = 0; p < 16; p++) begin
        if (p[o]) continue;
        begin
          int exp_o;
          exp_o = o;
          for (int k = NM - 1; k >= 1; k--)
            if (p[(o + k) % NM]) exp_o = (o + k) % NM;
          take(o);
          req_n = ~NM'(p);
          step(1);
          if (p == 0)
            check(gnt_n == gnt_of(o), "R3", "parked no gap", gnt_n, gnt_of(o));
          else
            check(gnt_n == '1, "R4", "handover gap", gnt_n, 4'hF);
          step(1);
          check(gnt_n == gnt_of(exp_o), (p == 0) ? "R3" : "R2",
                "next owner", gnt_n, gnt_of(exp_o));
          req_n = '1;
        end
      end
    end

    // R5: internal owner keeps the bus while requesting
    take(0);
    req_n = ~4'b0011;
    step(5);
    check(gnt_n == gnt_of(0), "R5", "internal kept", gnt_n, gnt_of(0));
    req_n = ~4'b0010;
    step(2);
    check(gnt_n == gnt_of(1), "R5", "handed on after release", gnt_n, gnt_of(1));
    req_n = '1;

    // R6: no move while busy; move after used transaction ends
    take(2);
    req_n = ~4'b1100;
    frame_n = 1'b0;
    step(4);
    check(gnt_n == gnt_of(2), "R6", "held during FRAME#", gnt_n, gnt_of(2));
    frame_n = 1'b1; irdy_n = 1'b0;
    step(1);
    check(gnt_n == gnt_of(2), "R6", "held during IRDY#", gnt_n, gnt_of(2));
    irdy_n = 1'b1;
    step(1);
    check(gnt_n == '1, "R6", "gap after transfer", gnt_n, 4'hF);
    step(1);
    check(gnt_n == gnt_of(3), "R6", "next after transfer", gnt_n, gnt_of(3));
    req_n = '1;

    // R7 / R10: idle timeout on an external owner
    take(2);
    step(15);
    check(broken_status == 1'b0, "R7", "status before limit", broken_status, 0);
    step(1);
    check(broken_status == 1'b1, "R7", "status at limit", broken_status, 1);
    check(irq == 1'b1, "R10", "irq enabled", irq, 1);
    check(gnt_n == gnt_of(2), "R3", "parked on broken owner", gnt_n, gnt_of(2));
    irq_en = 1'b0;
    #1;
    check(irq == 1'b0, "R10", "irq disabled", irq, 0);
    irq_en = 1'b1;

    // R8: mask until REQ# released
    req_n = ~4'b0110;
    step(2);
    check(gnt_n == gnt_of(1), "R8", "broken owner passed over", gnt_n, gnt_of(1));
    req_n = ~4'b0100;
    step(3);
    check(gnt_n == gnt_of(1), "R8", "masked request ignored", gnt_n, gnt_of(1));
    req_n = '1;
    step(1);
    req_n = ~4'b0100;
    step(2);
    check(gnt_n == gnt_of(2), "R8", "unmasked after release", gnt_n, gnt_of(2));

    // R9: FRAME# ignored after broken; timeout still fires and hands over
    req_n = ~4'b1100;
    frame_n = 1'b0;
    step(15);
    check(gnt_n == gnt_of(2), "R9", "before second timeout", gnt_n, gnt_of(2));
    step(2);
    check(gnt_n == gnt_of(3), "R9", "FRAME# ignored", gnt_n, gnt_of(3));
    frame_n = 1'b1;

    // R11: soft reset clears status and masks
    soft_rst = 1'b1;
    req_n = ~4'b0100;
    step(1);
    soft_rst = 1'b0;
    check(broken_status == 1'b0, "R11", "status cleared", broken_status, 0);
    check(gnt_n == '1, "R11", "gap on soft reset", gnt_n, 4'hF);
    step(1);
    check(gnt_n == gnt_of(0), "R11", "parked on 0", gnt_n, gnt_of(0));
    step(2);
    check(gnt_n == gnt_of(2), "R11", "mask cleared", gnt_n, gnt_of(2));

    // R7 coincidence: activity on the expiry clock wins
    step(15);
    frame_n = 1'b0;
    step(1);
    check(broken_status == 1'b0, "R7", "FRAME# on expiry clock", broken_status, 0);
    frame_n = 1'b1;
    req_n = '1;
    step(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule